// File: doc/BRIEF.md
# APB Secondary Interrupt Controller

This block gathers up to 64 level-sensitive interrupt lines and presents them to a primary interrupt controller as a single active-high level output. Each line has its own enable bit and its own mask bit. A line reaches the output only while it is raised, enabled and not masked. Software reaches the enable, mask and final-status words through an APB slave port that never inserts wait states and never reports an error.

The number of lines, `NUM_SRC`, is fixed at build time between 2 and 64. Line `n` below 32 sits at bit `n` of the low word of every register pair. Line `n` at 32 or above sits at bit `n-32` of the high word. Enable and mask bits for lines that do not exist have no storage: they drop writes and read as zero. Driver software can therefore find the line count by writing all ones to the enable words and reading them back.

The register port is plain APB rather than a valid/ready stream. The only flow control is `pready`, which is tied high, so the master can never be held off. The interrupt lines and the output are plain level signals with no handshake.

Top module: `apb_sec_irqc`

## Requirements
- R1: After reset is released, both enable words and both mask words read zero and `irq_out` is low.
- R2: Enable words sit at offset 0x00 (low, lines 0..31) and 0x04 (high, lines 32..63). A write in the APB access phase (psel, penable and pwrite all high) updates them, and a read returns the stored bits.
- R3: Enable bits at positions at or above `NUM_SRC` ignore writes and always read 0. With `NUM_SRC`=40, writing 0xFFFFFFFF to both enable words reads back 0xFFFFFFFF low and 0x000000FF high.
- R4: Mask words sit at offset 0x08 (low) and 0x0C (high) and are read/write. Mask bits at or above `NUM_SRC` also read 0.
- R5: Final status at offset 0x30 (low) and 0x34 (high) reads `irq_src & enable & ~mask` for each line. A set mask bit blocks its line. Writes to these offsets change nothing.
- R6: `irq_out` is the OR of all final-status bits, registered once on `pclk`. A change on `irq_src` or in a register is seen on `irq_out` after the next rising edge, and not before.
- R7: Reads of any other offset return 0, and writes to them leave every register unchanged.
- R8: `pready` is always 1 and `pslverr` is always 0. Read data is valid in the same access phase.
- R9: Line `n` appears in bit `n` of the low final-status word when `n` is below 32, and in bit `n-32` of the high word otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data; zero when psel is low |
| pready | output | 1 | Constant 1 (no wait states) |
| pslverr | output | 1 | Constant 0 |
| irq_src | input | NUM_SRC | Level-high interrupt lines |
| irq_out | output | 1 | Registered level-high request to the primary controller |

## Verification
The assertions assume well-formed APB traffic: `psel` is held for the setup and access phases, and `paddr` stays stable while `psel` is high. They also assume that `irq_src` changes only away from the rising edge of `pclk`. The bench meets these assumptions by driving every input on the falling edge and by holding the address and data across both APB phases. The assertions that compare `irq_out` with the final status one edge earlier check only after two cycles out of reset, so the reset value of the output register is never compared against stale status.

// File: rtl/sirqc_pkg.sv
package sirqc_pkg;

  localparam int unsigned MAX_SRC = 64;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned N_WORDS = MAX_SRC / WORD_W;

  localparam logic [31:0] OFF_EN_LO = 32'h00;
  localparam logic [31:0] OFF_EN_HI = 32'h04;
  localparam logic [31:0] OFF_MK_LO = 32'h08;
  localparam logic [31:0] OFF_MK_HI = 32'h0C;
  localparam logic [31:0] OFF_FS_LO = 32'h30;
  localparam logic [31:0] OFF_FS_HI = 32'h34;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_EN_LO,
    RS_EN_HI,
    RS_MK_LO,
    RS_MK_HI,
    RS_FS_LO,
    RS_FS_HI
  } regsel_e;

  // write strobe vector bit order
  localparam int unsigned WS_EN_LO = 0;
  localparam int unsigned WS_EN_HI = 1;
  localparam int unsigned WS_MK_LO = 2;
  localparam int unsigned WS_MK_HI = 3;

  function automatic regsel_e decode_off(input logic [31:0] off);
    regsel_e r;
    case (off)
      OFF_EN_LO: r = RS_EN_LO;
      OFF_EN_HI: r = RS_EN_HI;
      OFF_MK_LO: r = RS_MK_LO;
      OFF_MK_HI: r = RS_MK_HI;
      OFF_FS_LO: r = RS_FS_LO;
      OFF_FS_HI: r = RS_FS_HI;
      default:   r = RS_NONE;
    endcase
    return r;
  endfunction

  function automatic logic [MAX_SRC-1:0] impl_mask(input int unsigned n);
    logic [MAX_SRC-1:0] m;
    for (int unsigned i = 0; i < MAX_SRC; i++) m[i] = (i < n);
    return m;
  endfunction

endpackage

// File: rtl/sirqc_apb_port.sv
module sirqc_apb_port
  import sirqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [63:0]       en_q,
  input  logic [63:0]       mk_q,
  input  logic [63:0]       fin_stat,
  output logic [3:0]        wr_stb,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr
);

  regsel_e sel;
  logic    wr_go;
  logic [31:0] rd_mux;

  always_comb sel = decode_off(32'(paddr));

  assign wr_go = psel & penable & pwrite;

  always_comb begin
    wr_stb = '0;
    if (wr_go) begin
      case (sel)
        RS_EN_LO: wr_stb[WS_EN_LO] = 1'b1;
        RS_EN_HI: wr_stb[WS_EN_HI] = 1'b1;
        RS_MK_LO: wr_stb[WS_MK_LO] = 1'b1;
        RS_MK_HI: wr_stb[WS_MK_HI] = 1'b1;
        default:  wr_stb = '0;
      endcase
    end
  end

  always_comb begin
    case (sel)
      RS_EN_LO: rd_mux = en_q[31:0];
      RS_EN_HI: rd_mux = en_q[63:32];
      RS_MK_LO: rd_mux = mk_q[31:0];
      RS_MK_HI: rd_mux = mk_q[63:32];
      RS_FS_LO: rd_mux = fin_stat[31:0];
      RS_FS_HI: rd_mux = fin_stat[63:32];
      default:  rd_mux = '0;
    endcase
  end

  assign prdata  = psel ? rd_mux : 32'h0;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/sirqc_regbank.sv
module sirqc_regbank
  import sirqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  wr_stb,
  input  logic [31:0] wdata,
  output logic [63:0] en_q,
  output logic [63:0] mk_q
);

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  // one flop pair per existing line; absent lines read as constant zero
  for (genvar i = 0; i < MAX_SRC; i++) begin : g_bit
    localparam int unsigned W   = i / WORD_W;
    localparam int unsigned B   = i % WORD_W;
    localparam int unsigned SEN = (W == 0) ? WS_EN_LO : WS_EN_HI;
    localparam int unsigned SMK = (W == 0) ? WS_MK_LO : WS_MK_HI;
    if (i < NUM_SRC) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q[i] <= 1'b0;
          mk_q[i] <= 1'b0;
        end else begin
          if (wr_stb[SEN]) en_q[i] <= wdata[B];
          if (wr_stb[SMK]) mk_q[i] <= wdata[B];
        end
      end
    end else begin : g_absent
      assign en_q[i] = 1'b0;
      assign mk_q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/sirqc_combine.sv
module sirqc_combine
  import sirqc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] src_x,
  input  logic [63:0] en_q,
  input  logic [63:0] mk_q,
  output logic [63:0] fin_stat,
  output logic        irq_q
);

  logic [N_WORDS-1:0] word_any;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] fs_w;
    assign fs_w = src_x[w*WORD_W +: WORD_W]
                & en_q [w*WORD_W +: WORD_W]
                & ~mk_q[w*WORD_W +: WORD_W];
    assign fin_stat[w*WORD_W +: WORD_W] = fs_w;
    assign word_any[w] = |fs_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |word_any;
  end

endmodule

// File: rtl/apb_sec_irqc.sv
module apb_sec_irqc
  import sirqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic               irq_out
);

  logic [63:0] src_x;
  logic [63:0] en_q;
  logic [63:0] mk_q;
  logic [63:0] fin_stat;
  logic [3:0]  wr_stb;

  if (NUM_SRC >= MAX_SRC) begin : g_full
    assign src_x = irq_src[MAX_SRC-1:0];
  end else begin : g_pad
    assign src_x = {{(MAX_SRC-NUM_SRC){1'b0}}, irq_src};
  end

  sirqc_apb_port #(.ADDR_W(ADDR_W)) u_port (
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .en_q     (en_q),
    .mk_q     (mk_q),
    .fin_stat (fin_stat),
    .wr_stb   (wr_stb),
    .prdata   (prdata),
    .pready   (pready),
    .pslverr  (pslverr)
  );

  sirqc_regbank #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk    (pclk),
    .rst_n  (presetn),
    .wr_stb (wr_stb),
    .wdata  (pwdata),
    .en_q   (en_q),
    .mk_q   (mk_q)
  );

  sirqc_combine u_comb (
    .clk      (pclk),
    .rst_n    (presetn),
    .src_x    (src_x),
    .en_q     (en_q),
    .mk_q     (mk_q),
    .fin_stat (fin_stat),
    .irq_q    (irq_out)
  );

endmodule

// File: rtl/sirqc_chk.sv
module sirqc_chk
  import sirqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 12
) (
  input logic               pclk,
  input logic               presetn,
  input logic               psel,
  input logic [ADDR_W-1:0]  paddr,
  input logic [31:0]        prdata,
  input logic               pready,
  input logic               pslverr,
  input logic [NUM_SRC-1:0] irq_src,
  input logic               irq_out,
  input logic [63:0]        fin_stat
);

  localparam logic [63:0] IMPL = impl_mask(NUM_SRC);

  logic [1:0] up_cnt;
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)        up_cnt <= 2'd0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  logic hit_en_hi, hit_mk_hi, hit_map;
  assign hit_en_hi = (32'(paddr) == OFF_EN_HI);
  assign hit_mk_hi = (32'(paddr) == OFF_MK_HI);
  assign hit_map   = (decode_off(32'(paddr)) != RS_NONE);

  assert_quiet_out_R1: assert property (@(posedge pclk) disable iff (!presetn)
    (up_cnt == 2'd0) |-> !irq_out);

  assert_absent_en_zero_R3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && hit_en_hi) |-> ((prdata & ~IMPL[63:32]) == 32'h0));

  assert_absent_mk_zero_R4: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && hit_mk_hi) |-> ((prdata & ~IMPL[63:32]) == 32'h0));

  assert_stat_gated_R5: assert property (@(posedge pclk) disable iff (!presetn)
    ((fin_stat[NUM_SRC-1:0] & ~irq_src) == '0) && ((fin_stat & ~IMPL) == 64'h0));

  assert_out_lag_R6: assert property (@(posedge pclk) disable iff (!presetn)
    (up_cnt >= 2'd2) |-> (irq_out == $past(|fin_stat)));

  assert_unmapped_zero_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !hit_map) |-> (prdata == 32'h0));

  assert_no_wait_R8: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);

endmodule

bind apb_sec_irqc sirqc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .pclk     (pclk),
  .presetn  (presetn),
  .psel     (psel),
  .paddr    (paddr),
  .prdata   (prdata),
  .pready   (pready),
  .pslverr  (pslverr),
  .irq_src  (irq_src),
  .irq_out  (irq_out),
  .fin_stat (fin_stat)
);

// File: tb/sim_apb_sec_irqc.sv
`timescale 1ns/1ps
module sim_apb_sec_irqc;

  localparam int unsigned NSRC = 40;
  localparam int unsigned AW   = 12;

  logic pclk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic [NSRC-1:0] irq_src = '0;
  logic irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [63:0] impl, en_m, mk_m, lfsr;

  always #2 pclk = ~pclk;

  apb_sec_irqc #(.NUM_SRC(NSRC), .ADDR_W(AW)) u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq_src(irq_src), .irq_out(irq_out)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apb_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a[AW-1:0]; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a[AW-1:0];
    @(negedge pclk);
    penable = 1'b1;
    #1;
    d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic set_en(input logic [63:0] v);
    apb_wr(32'h00, v[31:0]);
    apb_wr(32'h04, v[63:32]);
    en_m = v & impl;
  endtask

  task automatic set_mk(input logic [63:0] v);
    apb_wr(32'h08, v[31:0]);
    apb_wr(32'h0C, v[63:32]);
    mk_m = v & impl;
  endtask

  function automatic logic [63:0] src64();
    return {{(64-NSRC){1'b0}}, irq_src};
  endfunction

  function automatic logic [63:0] exp_fs();
    return src64() & en_m & ~mk_m;
  endfunction

  task automatic check_fs(input string tag);
    logic [31:0] lo, hi;
    logic [63:0] e;
    e = exp_fs();
    apb_rd(32'h30, lo);
    apb_rd(32'h34, hi);
    check(tag, {hi, lo}, e);
  endtask

  task automatic settle();
    @(posedge pclk);
    @(negedge pclk);
  endtask

  function automatic logic [63:0] step(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  initial begin
    repeat (150000) @(posedge pclk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] r, r2;
    impl = (64'h1 << NSRC) - 64'h1;
    en_m = '0;
    mk_m = '0;
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R1 reset state
    apb_rd(32'h00, r); check("R1 en_lo", {32'h0, r}, 64'h0);
    apb_rd(32'h04, r); check("R1 en_hi", {32'h0, r}, 64'h0);
    apb_rd(32'h08, r); check("R1 mk_lo", {32'h0, r}, 64'h0);
    apb_rd(32'h0C, r); check("R1 mk_hi", {32'h0, r}, 64'h0);
    check("R1 irq_out", {63'h0, irq_out}, 64'h0);
    check("R8 pready/pslverr", {62'h0, pready, pslverr}, 64'h2);

    // R2 / R3 enable readback and source-count discovery
    set_en(64'hFFFF_FFFF_FFFF_FFFF);
    apb_rd(32'h00, r); apb_rd(32'h04, r2);
    check("R2 en_lo all ones", {32'h0, r}, 64'hFFFF_FFFF);
    check("R3 en_hi absent bits zero", {32'h0, r2}, {32'h0, impl[63:32]});
    begin
      int cnt = 0;
      for (int b = 0; b < 32; b++) if (r2[b]) cnt = 33 + b;
      if (r2 == 0) for (int b = 0; b < 32; b++) if (r[b]) cnt = b + 1;
      check("R3 discovered count", 64'(cnt), 64'(NSRC));
    end
    set_en(64'h0000_00A5_5A5A_0F0F);
    apb_rd(32'h00, r); apb_rd(32'h04, r2);
    check("R2 en pattern", {r2, r}, 64'h0000_00A5_5A5A_0F0F);

    // R4 mask readback
    set_mk(64'hFFFF_FFFF_FFFF_FFFF);
    apb_rd(32'h08, r); apb_rd(32'h0C, r2);
    check("R4 mask all ones", {r2, r}, impl);
    set_mk(64'h0);
    apb_rd(32'h08, r); apb_rd(32'h0C, r2);
    check("R4 mask cleared", {r2, r}, 64'h0);

    // R9 / R5 / R6 sweep every line
    for (int n = 0; n < NSRC; n++) begin
      set_en(64'h1 << n);
      @(negedge pclk);
      irq_src = NSRC'(64'h1 << n);
      settle();
      check_fs($sformatf("R9 line %0d status", n));
      check($sformatf("R6 line %0d irq_out", n), {63'h0, irq_out}, 64'h1);
      set_mk(64'h1 << n);
      settle();
      check($sformatf("R5 line %0d masked irq_out", n), {63'h0, irq_out}, 64'h0);
      check_fs($sformatf("R5 line %0d masked status", n));
      set_mk(64'h0);
      set_en(~(64'h1 << n));
      settle();
      check($sformatf("R5 line %0d disabled irq_out", n), {63'h0, irq_out}, 64'h0);
    end

    // R6 latency
    set_en(64'hFFFF_FFFF_FFFF_FFFF);
    set_mk(64'h0);
    @(negedge pclk);
    irq_src = '0;
    settle();
    check("R6 idle", {63'h0, irq_out}, 64'h0);
    @(negedge pclk);
    irq_src = NSRC'(64'h20);
    #1;
    check("R6 no same-cycle change", {63'h0, irq_out}, 64'h0);
    settle();
    check("R6 one edge later", {63'h0, irq_out}, 64'h1);

    // R5 pseudo-random patterns
    lfsr = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 24; k++) begin
      lfsr = step(lfsr); set_en(lfsr);
      lfsr = step(lfsr); set_mk(lfsr);
      lfsr = step(lfsr);
      @(negedge pclk);
      irq_src = lfsr[NSRC-1:0];
      settle();
      check_fs($sformatf("R5 pattern %0d status", k));
      check($sformatf("R6 pattern %0d irq_out", k), {63'h0, irq_out}, {63'h0, |exp_fs()});
    end

    // R5 status read-only, R7 unmapped offsets
    set_en(64'h0000_0012_3456_789A);
    set_mk(64'h0000_0001_0000_0001);
    @(negedge pclk);
    irq_src = '1;
    settle();
    apb_wr(32'h30, 32'h0);
    apb_wr(32'h34, 32'hFFFF_FFFF);
    check_fs("R5 status after writes");
    apb_rd(32'h00, r); apb_rd(32'h04, r2);
    check("R5 enable untouched by status write", {r2, r}, en_m);
    apb_wr(32'h10, 32'hFFFF_FFFF);
    apb_wr(32'h38, 32'hFFFF_FFFF);
    apb_wr(32'h02, 32'hFFFF_FFFF);
    apb_rd(32'h00, r); apb_rd(32'h04, r2);
    check("R7 enable untouched", {r2, r}, en_m);
    apb_rd(32'h08, r); apb_rd(32'h0C, r2);
    check("R7 mask untouched", {r2, r}, mk_m);
    apb_rd(32'h10, r); check("R7 read 0x10", {32'h0, r}, 64'h0);
    apb_rd(32'h3C, r); check("R7 read 0x3C", {32'h0, r}, 64'h0);
    apb_rd(32'h02, r); check("R7 read unaligned", {32'h0, r}, 64'h0);
    check("R8 pready/pslverr end", {62'h0, pready, pslverr}, 64'h2);

    report();
  end

endmodule